// File: doc/BRIEF.md
# Frame Ring Transmit Scheduler

This block keeps track of who owns each buffer in a ring of video frame buffers that a producer fills and a DMA engine drains. Each frame is either CLEAR, meaning it waits for data, or READY, meaning it holds a complete frame queued for sending. The producer marks frames READY with an index. The DMA side pulses an end-of-frame strobe each time it finishes sending the active frame.

At each end-of-frame the scheduler looks at the frame after the active one. If that frame is READY, the active pointer moves onto it and the finished frame goes back to CLEAR. If it is CLEAR, the current frame is sent again and a drop counter counts the repeat. The active pointer never lands on a CLEAR frame. Start and stop controls switch the consumer side on and off. While it is stopped, the active index reads as minus one.

Status outputs report the active index, the producer's next expected index (the first clear index), the number of CLEAR frames, the drop count and a full flag. Data movement is not part of this block.

Top module: `frame_ring_sched`

## Requirements
- R1: After reset all frames are CLEAR. The outputs read: active_idx all ones (minus one), first_clear 0, clear_cnt NFRAMES, drop_cnt 0, ring_full 0 and mark_err 0.
- R2: mark_req on a CLEAR frame while the ring is not full is accepted. That frame becomes READY, clear_cnt drops by one and first_clear becomes mark_idx+1, wrapping from NFRAMES-1 to 0.
- R3: mark_req on a READY frame, or while ring_full is 1, is ignored. In that case mark_err is 1 for one cycle and first_clear and clear_cnt do not change.
- R4: ring_full is 1 exactly when the frame at first_clear is READY.
- R5: start while stopped sets active_idx to start_idx if that frame is READY. If the frame is CLEAR, the block stays stopped. start while running is ignored.
- R6: eof while running, with the next frame (active+1, wrapping from NFRAMES-1 to 0) READY, moves active_idx to that frame. The finished frame becomes CLEAR and clear_cnt rises by one.
- R7: eof while running, with the next frame CLEAR, leaves active_idx unchanged and raises drop_cnt by one. clear_cnt does not change.
- R8: An accepted mark and an advancing eof in the same cycle leave clear_cnt unchanged. The eof decision uses the frame states from before that cycle.
- R9: stop makes active_idx all ones one cycle later and takes priority over a same-cycle eof. eof while stopped changes neither drop_cnt nor clear_cnt.
- R10: With DROP_SAT=1, drop_cnt holds at its maximum value (2^DROP_W-1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_req | input | 1 | Producer request to mark a frame READY |
| mark_idx | input | IDX_W | Frame index for mark_req |
| eof | input | 1 | End-of-frame strobe from the DMA side |
| start | input | 1 | Start the consumer at start_idx |
| start_idx | input | IDX_W | First frame to send on start |
| stop | input | 1 | Stop the consumer |
| active_idx | output | IDX_W+1 | Signed active frame index, all ones while stopped |
| first_clear | output | IDX_W | Next index the producer is expected to fill |
| clear_cnt | output | IDX_W+1 | Number of CLEAR frames |
| drop_cnt | output | DROP_W | Number of repeated frames |
| ring_full | output | 1 | Frame at first_clear is READY |
| mark_err | output | 1 | One-cycle pulse for a rejected mark request |

## Verification
Every output of this block comes from a register, including the mark_err pulse. Each result is therefore due at the first rising edge after the stimulus that causes it. The bench drives inputs on the falling edge and compares all outputs at the next falling edge, exactly one edge later. For the saturation run, the bench drives a series of eof strobes into a CLEAR successor and checks the count only after the final pulse has been registered.

// File: rtl/frs_pkg.sv
package frs_pkg;
   // successor of a ring index, wrapping at depth
   function automatic int unsigned ring_next(int unsigned cur, int unsigned depth);
      return (cur + 1 >= depth) ? 0 : cur + 1;
   endfunction
endpackage

// File: rtl/frs_state_bank.sv
module frs_state_bank #(
   parameter int NFRAMES = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_idx,
   output logic [NFRAMES-1:0] ready_o
);
   for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set_en && set_idx == IDX_W'(i))
            bit_q <= 1'b1;
         else if (clr_en && clr_idx == IDX_W'(i))
            bit_q <= 1'b0;
      end
      assign ready_o[i] = bit_q;
   end
endmodule

// File: rtl/frs_producer.sv
module frs_producer
   import frs_pkg::*;
#(
   parameter int NFRAMES = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mark_req,
   input  logic [IDX_W-1:0]   mark_idx,
   input  logic [NFRAMES-1:0] ready_i,
   output logic               accept_o,
   output logic [IDX_W-1:0]   first_o,
   output logic               full_o,
   output logic               err_o
);
   logic [IDX_W-1:0] first_q;
   logic             err_q;
   logic             idx_ok;

   assign idx_ok   = 32'(mark_idx) < NFRAMES;
   assign full_o   = ready_i[first_q];
   assign accept_o = mark_req && idx_ok && !ready_i[mark_idx] && !full_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= mark_req && !accept_o;
         if (accept_o)
            first_q <= IDX_W'(ring_next(32'(mark_idx), NFRAMES));
      end
   end

   assign first_o = first_q;
   assign err_o   = err_q;
endmodule

// File: rtl/frs_consumer.sv
module frs_consumer
   import frs_pkg::*;
#(
   parameter int NFRAMES  = 4,
   parameter int IDX_W    = 2,
   parameter int DROP_W   = 16,
   parameter bit DROP_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eof,
   input  logic               start,
   input  logic [IDX_W-1:0]   start_idx,
   input  logic               stop,
   input  logic [NFRAMES-1:0] ready_i,
   output logic               run_o,
   output logic [IDX_W-1:0]   act_o,
   output logic               done_o,
   output logic [IDX_W-1:0]   done_idx_o,
   output logic [DROP_W-1:0]  drop_o
);
   logic              run_q;
   logic [IDX_W-1:0]  act_q;
   logic [IDX_W-1:0]  nxt;
   logic              start_ok;
   logic              miss;
   logic [DROP_W-1:0] drop_q;

   assign nxt      = IDX_W'(ring_next(32'(act_q), NFRAMES));
   assign start_ok = (32'(start_idx) < NFRAMES) && ready_i[start_idx];
   assign done_o   = run_q && eof && !stop && ready_i[nxt];
   assign miss     = run_q && eof && !stop && !ready_i[nxt];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         act_q <= '0;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (!run_q && start && start_ok) begin
         run_q <= 1'b1;
         act_q <= start_idx;
      end else if (done_o) begin
         act_q <= nxt;
      end
   end

   if (DROP_SAT) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            drop_q <= '0;
         else if (miss && drop_q != '1)
            drop_q <= drop_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            drop_q <= '0;
         else if (miss)
            drop_q <= drop_q + 1'b1;
      end
   end

   assign run_o      = run_q;
   assign act_o      = act_q;
   assign done_idx_o = act_q;
   assign drop_o     = drop_q;
endmodule

// File: rtl/frame_ring_sched.sv
module frame_ring_sched #(
   parameter int NFRAMES  = 4,
   parameter int DROP_W   = 16,
   parameter bit DROP_SAT = 1'b1,
   localparam int IDX_W   = $clog2(NFRAMES),
   localparam int CNT_W   = IDX_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mark_req,
   input  logic [IDX_W-1:0]        mark_idx,
   input  logic                    eof,
   input  logic                    start,
   input  logic [IDX_W-1:0]        start_idx,
   input  logic                    stop,
   output logic signed [IDX_W:0]   active_idx,
   output logic [IDX_W-1:0]        first_clear,
   output logic [CNT_W-1:0]        clear_cnt,
   output logic [DROP_W-1:0]       drop_cnt,
   output logic                    ring_full,
   output logic                    mark_err
);
   if (NFRAMES < 2) begin : g_bad_depth
      $error("frame_ring_sched: NFRAMES must be at least 2");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("frame_ring_sched: DROP_W must be at least 1");
   end

   logic [NFRAMES-1:0] ready_q;
   logic               accept;
   logic               done;
   logic [IDX_W-1:0]   done_idx;
   logic               running;
   logic [IDX_W-1:0]   act;
   logic [CNT_W-1:0]   cnt_q;

   frs_state_bank #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(accept), .set_idx(mark_idx),
      .clr_en(done), .clr_idx(done_idx),
      .ready_o(ready_q)
   );

   frs_producer #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_prod (
      .clk(clk), .rst_n(rst_n),
      .mark_req(mark_req), .mark_idx(mark_idx), .ready_i(ready_q),
      .accept_o(accept), .first_o(first_clear), .full_o(ring_full),
      .err_o(mark_err)
   );

   frs_consumer #(.NFRAMES(NFRAMES), .IDX_W(IDX_W), .DROP_W(DROP_W),
                  .DROP_SAT(DROP_SAT)) u_cons (
      .clk(clk), .rst_n(rst_n),
      .eof(eof), .start(start), .start_idx(start_idx), .stop(stop),
      .ready_i(ready_q),
      .run_o(running), .act_o(act), .done_o(done), .done_idx_o(done_idx),
      .drop_o(drop_cnt)
   );

   // clear count: mark takes one away, completion gives one back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(NFRAMES);
      else begin
         case ({accept, done})
            2'b10:   cnt_q <= cnt_q - 1'b1;
            2'b01:   cnt_q <= cnt_q + 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign clear_cnt  = cnt_q;
   assign active_idx = running ? $signed({1'b0, act}) : '1;
endmodule

// File: rtl/frame_ring_sched_chk.sv
module frame_ring_sched_chk #(
   parameter int NFRAMES = 4,
   parameter int DROP_W  = 16,
   parameter int IDX_W   = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mark_req,
   input logic                  stop,
   input logic signed [IDX_W:0] active_idx,
   input logic [IDX_W-1:0]      first_clear,
   input logic [IDX_W:0]        clear_cnt,
   input logic [DROP_W-1:0]     drop_cnt,
   input logic                  ring_full,
   input logic [NFRAMES-1:0]    ready_q
);
   p_clear_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(clear_cnt) <= NFRAMES);

   p_full_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_req && ring_full) |=> $stable(first_clear));

   p_full_has_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ring_full |-> (32'(clear_cnt) < NFRAMES));

   p_active_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_idx[IDX_W] |-> ready_q[active_idx[IDX_W-1:0]]);

   p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1)));

   p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> active_idx[IDX_W]);
endmodule

bind frame_ring_sched frame_ring_sched_chk #(
   .NFRAMES(NFRAMES), .DROP_W(DROP_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mark_req(mark_req), .stop(stop),
   .active_idx(active_idx), .first_clear(first_clear), .clear_cnt(clear_cnt),
   .drop_cnt(drop_cnt), .ring_full(ring_full), .ready_q(ready_q)
);

// File: tb/frame_ring_sched_tb.sv
`timescale 1ns/1ps
module frame_ring_sched_tb;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mark_req = 1'b0;
   logic [1:0]        mark_idx = '0;
   logic              eof = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        start_idx = '0;
   logic              stop = 1'b0;
   logic signed [2:0] active_idx;
   logic [1:0]        first_clear;
   logic [2:0]        clear_cnt;
   logic [3:0]        drop_cnt;
   logic              ring_full;
   logic              mark_err;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   frame_ring_sched #(.NFRAMES(4), .DROP_W(4), .DROP_SAT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mark_req(mark_req), .mark_idx(mark_idx),
      .eof(eof), .start(start), .start_idx(start_idx), .stop(stop),
      .active_idx(active_idx), .first_clear(first_clear),
      .clear_cnt(clear_cnt), .drop_cnt(drop_cnt), .ring_full(ring_full),
      .mark_err(mark_err)
   );

   typedef struct packed {
      logic       mk; logic [1:0] mi; logic eo; logic st; logic [1:0] si; logic sp;
      logic [2:0] xa; logic [1:0] xf; logic [2:0] xc; logic [3:0] xd;
      logic       xfl; logic xer; logic [3:0] rq;
   } vec_t;

   // mk mi eo st si sp | active first clear drop full err | req
   localparam vec_t VECS [18] = '{
      '{0,0,0,0,0,0, 7,0,4,0,0,0,  1},  // R1 idle after reset
      '{1,0,0,0,0,0, 7,1,3,0,0,0,  2},  // R2 mark 0
      '{1,1,0,0,0,0, 7,2,2,0,0,0,  2},  // R2 mark 1
      '{1,1,0,0,0,0, 7,2,2,0,0,1,  3},  // R3 mark READY frame
      '{0,0,0,1,2,0, 7,2,2,0,0,0,  5},  // R5 start on CLEAR frame
      '{0,0,0,1,0,0, 0,2,2,0,0,0,  5},  // R5 start on frame 0
      '{0,0,1,0,0,0, 1,2,3,0,0,0,  6},  // R6 advance
      '{0,0,1,0,0,0, 1,2,3,1,0,0,  7},  // R7 repeat, drop
      '{1,2,0,0,0,0, 1,3,2,1,0,0,  2},  // R2 mark 2
      '{1,3,1,0,0,0, 2,0,2,1,0,0,  8},  // R8 mark + advance
      '{1,0,0,0,0,0, 2,1,1,1,0,0,  2},  // R2 mark 0
      '{1,1,0,0,0,0, 2,2,0,1,1,0,  4},  // R4 full
      '{1,2,0,0,0,0, 2,2,0,1,1,1,  3},  // R3 mark while full
      '{0,0,1,0,0,0, 3,2,1,1,0,0,  6},  // R6 advance, not full
      '{0,0,1,0,0,0, 0,2,2,1,0,0,  6},  // R6 wrap 3 to 0
      '{0,0,1,0,0,1, 7,2,2,1,0,0,  9},  // R9 stop beats eof
      '{0,0,1,0,0,0, 7,2,2,1,0,0,  9},  // R9 eof while stopped
      '{0,0,0,1,1,0, 1,2,2,1,0,0,  5}   // R5 restart on frame 1
   };

   task automatic clear_inputs();
      mark_req = 1'b0; eof = 1'b0; start = 1'b0; stop = 1'b0;
   endtask

   task automatic check_all(input string tag, input logic [2:0] xa,
                            input logic [1:0] xf, input logic [2:0] xc,
                            input logic [3:0] xd, input logic xfl, input logic xer);
      checks++;
      if ($unsigned(active_idx) != xa || first_clear != xf || clear_cnt != xc ||
          drop_cnt != xd || ring_full != xfl || mark_err != xer) begin
         errors++;
         $display("FAIL %s: act=%0d first=%0d clr=%0d drop=%0d full=%0b err=%0b expected act=%0d first=%0d clr=%0d drop=%0d full=%0b err=%0b",
                  tag, $unsigned(active_idx), first_clear, clear_cnt, drop_cnt,
                  ring_full, mark_err, xa, xf, xc, xd, xfl, xer);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 18; i++) begin
         mark_req = VECS[i].mk; mark_idx = VECS[i].mi; eof = VECS[i].eo;
         start = VECS[i].st; start_idx = VECS[i].si; stop = VECS[i].sp;
         @(negedge clk);
         clear_inputs();
         check_all($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].xa,
                   VECS[i].xf, VECS[i].xc, VECS[i].xd, VECS[i].xfl, VECS[i].xer);
      end

      // R7/R10: active 1, successor 2 is CLEAR; drive 17 repeats
      for (int k = 0; k < 14; k++) begin
         eof = 1'b1;
         @(negedge clk);
      end
      clear_inputs();
      check_all("R7 fourteen repeats reach 15", 3'd1, 2'd2, 3'd2, 4'd15, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) begin
         eof = 1'b1;
         @(negedge clk);
      end
      clear_inputs();
      check_all("R10 drop count saturates", 3'd1, 2'd2, 3'd2, 4'd15, 1'b0, 1'b0);

      // R1: reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      check_all("R1 reset state", 3'd7, 2'd0, 3'd4, 4'd0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 state after reset release", 3'd7, 2'd0, 3'd4, 4'd0, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule